// File: doc/BRIEF.md
# Byte-Lane Execution Unit

This unit performs byte-granular operations on 64-bit integers for an integer pipeline. It works on eight byte lanes. An 8-bit select value expands into a 64-bit lane mask, where each set bit enables one whole byte lane. The mask is then combined with byte-lane shifts. The operations are:

- keep selected bytes;
- clear selected bytes;
- extract-low, extract-high and insert-low, each in byte, word, longword and quadword sizes.

Operand B is either a register value or an 8-bit literal. A flag picks which one is used. The low three bits of the chosen value give the lane offset for the shifting operations. Register index 31 is the hard-wired zero register:

- As a source, it forces a zero result.
- As a destination, it suppresses the write.

The datapath is combinational. A single output register captures the result, write-enable and illegal-op flag on each cycle in which the valid strobe is high.

Top module: `byte_lane_unit`

## Requirements
- R1: Function code 0x31 (keep) returns A AND M(s), where s is the select value. M(s) sets bits 8i+7..8i to ones exactly when bit i of s is one. Select values 0x00, 0x01, 0x03, 0x0F and 0xFF give zero, 8-bit, 16-bit and 32-bit zero-extension, and A unchanged.
- R2: Function code 0x30 (clear) returns A AND M(NOT s).
- R3: The select value s is the literal input when the literal flag is 1, and bits 7..0 of operand B otherwise. Upper B bits and the unused source have no effect. The lane offset k is s[2:0].
- R4: Codes 0x06, 0x16, 0x26 and 0x36 (extract-low, sizes byte, word, longword and quadword) return (A >> 8k) AND M(size).
- R5: Codes 0x5A, 0x6A and 0x7A (extract-high, sizes word, longword and quadword) return (A << ((64 - 8k) mod 64)) AND M(size). An offset of 0 therefore applies no shift.
- R6: Codes 0x0B, 0x1B, 0x2B and 0x3B (insert-low, sizes byte, word, longword and quadword) return (A AND M(size)) << 8k. Bits shifted past bit 63 are lost.
- R7: The size selects are 0x01 for byte, 0x03 for word, 0x0F for longword and 0xFF for quadword.
- R8: A source-A index of 31 forces a zero result.
- R9: A destination index of 31 deasserts the write-enable. The result is still produced.
- R10: Any other function code sets the illegal flag, deasserts the write-enable and gives a zero result.
- R11: Outputs update on the clock edge at which valid is high, so they appear one cycle later. After a cycle with valid low, the write-enable and illegal flag are 0 and the result holds its previous value.
- R12: While reset is active, the result, write-enable and illegal flag are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| valid_i | input | 1 | Operation strobe; loads the output register |
| func_i | input | 7 | Function code |
| opa_i | input | 64 | Operand A |
| opb_i | input | 64 | Operand B register value |
| lit_i | input | 8 | Literal operand |
| use_lit_i | input | 1 | 1 selects the literal as operand B |
| src_a_idx_i | input | 5 | Source-A register index |
| dst_idx_i | input | 5 | Destination register index |
| result_o | output | 64 | Registered result |
| wr_en_o | output | 1 | Registered write-enable |
| illegal_o | output | 1 | Registered illegal-op flag |

## Verification
The assertions check, on every cycle, the behaviours that depend only on indices, codes and the strobe:

- a zero source forces a zero result;
- a zero destination gives no write;
- an illegal op never writes;
- an idle cycle clears the write-enable and holds the result;
- a byte insert never fills more than one lane;
- a keep with the all-ones select passes A through.

The lane arithmetic itself can only be shown by the bench's scenarios. These cover extract and insert offsets at 0, mid-range and 7, the special select values, literal versus register sourcing with garbage in the unused source, and the wrap of the extract-high shift.

// File: rtl/bmu_pkg.sv
package bmu_pkg;
    localparam int DATA_W   = 64;
    localparam int LANES    = DATA_W / 8;
    localparam int OFS_W    = $clog2(LANES);
    localparam int FUNC_W   = 7;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_KEEP,
        OP_CLEAR,
        OP_EXT_LO,
        OP_EXT_HI,
        OP_INS_LO
    } op_e;

    typedef struct packed {
        logic [DATA_W-1:0] result;
        logic              wr_en;
        logic              illegal;
    } out_s;
endpackage

// File: rtl/bmu_decode.sv
module bmu_decode
    import bmu_pkg::*;
(
    input  logic [FUNC_W-1:0] func_i,
    output op_e               op_o,
    output logic [LANES-1:0]  size_sel_o,
    output logic              illegal_o
);
    always_comb begin
        op_o       = OP_NONE;
        size_sel_o = '0;
        illegal_o  = 1'b0;
        case (func_i)
            7'h31: op_o = OP_KEEP;
            7'h30: op_o = OP_CLEAR;
            7'h06: begin op_o = OP_EXT_LO; size_sel_o = 8'h01; end
            7'h16: begin op_o = OP_EXT_LO; size_sel_o = 8'h03; end
            7'h26: begin op_o = OP_EXT_LO; size_sel_o = 8'h0F; end
            7'h36: begin op_o = OP_EXT_LO; size_sel_o = 8'hFF; end
            7'h5A: begin op_o = OP_EXT_HI; size_sel_o = 8'h03; end
            7'h6A: begin op_o = OP_EXT_HI; size_sel_o = 8'h0F; end
            7'h7A: begin op_o = OP_EXT_HI; size_sel_o = 8'hFF; end
            7'h0B: begin op_o = OP_INS_LO; size_sel_o = 8'h01; end
            7'h1B: begin op_o = OP_INS_LO; size_sel_o = 8'h03; end
            7'h2B: begin op_o = OP_INS_LO; size_sel_o = 8'h0F; end
            7'h3B: begin op_o = OP_INS_LO; size_sel_o = 8'hFF; end
            default: illegal_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/bmu_mask_expand.sv
module bmu_mask_expand
    import bmu_pkg::*;
#(
    parameter int N_LANES = LANES
) (
    input  logic [N_LANES-1:0]   sel_i,
    output logic [8*N_LANES-1:0] mask_o
);
    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        assign mask_o[8*i +: 8] = {8{sel_i[i]}};
    end
endmodule

// File: rtl/byte_lane_unit.sv
module byte_lane_unit
    import bmu_pkg::*;
#(
    parameter int IDX_W    = 5,
    parameter int ZERO_IDX = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_i,
    input  logic [FUNC_W-1:0] func_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [LANES-1:0]  lit_i,
    input  logic              use_lit_i,
    input  logic [IDX_W-1:0]  src_a_idx_i,
    input  logic [IDX_W-1:0]  dst_idx_i,
    output logic [DATA_W-1:0] result_o,
    output logic              wr_en_o,
    output logic              illegal_o
);
    localparam int SH_W = OFS_W + 3;

    op_e               op;
    logic [LANES-1:0]  size_sel;
    logic              dec_illegal;
    logic [LANES-1:0]  sel;
    logic [LANES-1:0]  mask_sel;
    logic [DATA_W-1:0] mask;
    logic [OFS_W-1:0]  ofs;
    logic [SH_W-1:0]   sh_lo, sh_hi;
    logic [DATA_W-1:0] calc;
    out_s              out_d, out_q;

    bmu_decode i_decode (
        .func_i     (func_i),
        .op_o       (op),
        .size_sel_o (size_sel),
        .illegal_o  (dec_illegal)
    );

    always_comb begin
        sel = use_lit_i ? lit_i : opb_i[LANES-1:0];
        ofs = sel[OFS_W-1:0];
        unique case (op)
            OP_KEEP:  mask_sel = sel;
            OP_CLEAR: mask_sel = ~sel;
            default:  mask_sel = size_sel;
        endcase
    end

    bmu_mask_expand #(.N_LANES(LANES)) i_expand (
        .sel_i  (mask_sel),
        .mask_o (mask)
    );

    always_comb begin
        sh_lo = {ofs, 3'b000};
        sh_hi = {OFS_W'(0) - ofs, 3'b000};
        case (op)
            OP_EXT_LO: calc = (opa_i >> sh_lo) & mask;
            OP_EXT_HI: calc = (opa_i << sh_hi) & mask;
            OP_INS_LO: calc = (opa_i & mask) << sh_lo;
            OP_KEEP,
            OP_CLEAR:  calc = opa_i & mask;
            default:   calc = '0;
        endcase
    end

    always_comb begin
        out_d         = out_q;
        out_d.wr_en   = 1'b0;
        out_d.illegal = 1'b0;
        if (valid_i) begin
            out_d.illegal = dec_illegal;
            out_d.wr_en   = !dec_illegal && (dst_idx_i != IDX_W'(ZERO_IDX));
            out_d.result  = (dec_illegal || src_a_idx_i == IDX_W'(ZERO_IDX)) ? '0 : calc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign result_o  = out_q.result;
    assign wr_en_o   = out_q.wr_en;
    assign illegal_o = out_q.illegal;

    logic [LANES-1:0] res_lane_nz;
    always_comb begin
        for (int i = 0; i < LANES; i++) res_lane_nz[i] = |result_o[8*i +: 8];
    end

    a_r8_zero_src: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && src_a_idx_i == IDX_W'(ZERO_IDX) |=> result_o == '0);
    a_r9_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && dst_idx_i == IDX_W'(ZERO_IDX) |=> !wr_en_o);
    a_r10_illegal_nowrite: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !wr_en_o && result_o == '0);
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !wr_en_o && !illegal_o && $stable(result_o));
    a_r6_insb_one_lane: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && func_i == 7'h0B |=> $countones(res_lane_nz) <= 1);
    a_r1_keep_all: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i && func_i == 7'h31 && sel == '1 && src_a_idx_i != IDX_W'(ZERO_IDX)
        |=> result_o == $past(opa_i));
endmodule

// File: tb/test_byte_lane_unit.sv
`timescale 1ns/1ps
module test_byte_lane_unit;
    typedef struct packed {
        logic [6:0]  func;
        logic [63:0] a;
        logic [63:0] b;
        logic [7:0]  lit;
        logic        use_lit;
        logic [4:0]  ra;
        logic [4:0]  rc;
        logic [63:0] exp_res;
        logic        exp_we;
        logic        exp_ill;
    } vec_t;

    localparam logic [63:0] A = 64'h8877665544332211;
    localparam logic [63:0] G = 64'hDEADBEEFCAFEF00D;
    localparam int NV = 21;
    localparam vec_t VECS [NV] = '{
        '{7'h31, A, G, 8'h00, 1'b1, 5'd1, 5'd2, 64'h0, 1'b1, 1'b0},                 // R1 zero
        '{7'h31, A, G, 8'h01, 1'b1, 5'd1, 5'd2, 64'h11, 1'b1, 1'b0},                // R1 8-bit
        '{7'h31, A, G, 8'h03, 1'b1, 5'd1, 5'd2, 64'h2211, 1'b1, 1'b0},              // R1 16-bit
        '{7'h31, A, G, 8'h0F, 1'b1, 5'd1, 5'd2, 64'h44332211, 1'b1, 1'b0},          // R1 32-bit
        '{7'h31, A, G, 8'hFF, 1'b1, 5'd1, 5'd2, A, 1'b1, 1'b0},                     // R1 pass
        '{7'h31, A, 64'hFFFFFFFFFFFFFFA5, 8'h00, 1'b0, 5'd1, 5'd2,
          64'h8800660000330011, 1'b1, 1'b0},                                        // R3 reg source
        '{7'h30, A, G, 8'hA5, 1'b1, 5'd1, 5'd2, 64'h0077005544002200, 1'b1, 1'b0},  // R2
        '{7'h06, A, 64'h3, 8'hFF, 1'b0, 5'd1, 5'd2, 64'h44, 1'b1, 1'b0},            // R4 R7 byte
        '{7'h16, A, G, 8'h0E, 1'b1, 5'd1, 5'd2, 64'h8877, 1'b1, 1'b0},              // R4 word
        '{7'h26, A, G, 8'h05, 1'b1, 5'd1, 5'd2, 64'h887766, 1'b1, 1'b0},            // R4 long
        '{7'h36, A, G, 8'h02, 1'b1, 5'd1, 5'd2, 64'h0000887766554433, 1'b1, 1'b0},  // R4 quad
        '{7'h5A, A, G, 8'h07, 1'b1, 5'd1, 5'd2, 64'h1100, 1'b1, 1'b0},              // R5 word
        '{7'h6A, A, G, 8'h00, 1'b1, 5'd1, 5'd2, 64'h44332211, 1'b1, 1'b0},          // R5 offset 0
        '{7'h7A, A, G, 8'h03, 1'b1, 5'd1, 5'd2, 64'h3322110000000000, 1'b1, 1'b0},  // R5 quad
        '{7'h0B, A, G, 8'h05, 1'b1, 5'd1, 5'd2, 64'h0000110000000000, 1'b1, 1'b0},  // R6 byte
        '{7'h1B, A, G, 8'h07, 1'b1, 5'd1, 5'd2, 64'h1100000000000000, 1'b1, 1'b0},  // R6 word lost
        '{7'h2B, A, G, 8'h06, 1'b1, 5'd1, 5'd2, 64'h2211000000000000, 1'b1, 1'b0},  // R6 long
        '{7'h3B, A, 64'h9, 8'hFF, 1'b0, 5'd1, 5'd2, 64'h7766554433221100, 1'b1, 1'b0}, // R6 quad
        '{7'h31, A, G, 8'hFF, 1'b1, 5'd31, 5'd2, 64'h0, 1'b1, 1'b0},                // R8
        '{7'h31, A, G, 8'hFF, 1'b1, 5'd1, 5'd31, A, 1'b0, 1'b0},                    // R9
        '{7'h05, A, G, 8'hFF, 1'b1, 5'd1, 5'd2, 64'h0, 1'b0, 1'b1}                  // R10
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0;
    logic [6:0]  func_i = '0;
    logic [63:0] opa_i = '0, opb_i = '0;
    logic [7:0]  lit_i = '0;
    logic        use_lit_i = 1'b0;
    logic [4:0]  src_a_idx_i = '0, dst_idx_i = '0;
    logic [63:0] result_o;
    logic        wr_en_o, illegal_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    byte_lane_unit i_byte_lane_unit (
        .clk(clk), .rst_n(rst_n), .valid_i(valid_i), .func_i(func_i),
        .opa_i(opa_i), .opb_i(opb_i), .lit_i(lit_i), .use_lit_i(use_lit_i),
        .src_a_idx_i(src_a_idx_i), .dst_idx_i(dst_idx_i),
        .result_o(result_o), .wr_en_o(wr_en_o), .illegal_o(illegal_o)
    );

    task automatic check(string req, logic [63:0] res, logic we, logic ill);
        n_chk++;
        if (result_o !== res || wr_en_o !== we || illegal_o !== ill) begin
            n_bad++;
            $display("FAIL %s: got res=%h we=%b ill=%b, expected res=%h we=%b ill=%b",
                     req, result_o, wr_en_o, illegal_o, res, we, ill);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout, expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R12 reset", 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R12 after release", 64'h0, 1'b0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            valid_i     = 1'b1;
            func_i      = VECS[i].func;
            opa_i       = VECS[i].a;
            opb_i       = VECS[i].b;
            lit_i       = VECS[i].lit;
            use_lit_i   = VECS[i].use_lit;
            src_a_idx_i = VECS[i].ra;
            dst_idx_i   = VECS[i].rc;
            @(negedge clk);
            valid_i = 1'b0;
            check($sformatf("vector %0d", i), VECS[i].exp_res, VECS[i].exp_we, VECS[i].exp_ill);
        end

        // R11: load a result, then idle cycles with changed inputs must hold it
        @(negedge clk);
        valid_i = 1'b1; func_i = 7'h31; opa_i = A; lit_i = 8'h0F; use_lit_i = 1'b1;
        src_a_idx_i = 5'd1; dst_idx_i = 5'd2;
        @(negedge clk);
        valid_i = 1'b0; func_i = 7'h05; opa_i = G; src_a_idx_i = 5'd31;
        check("R11 one-cycle latency", 64'h44332211, 1'b1, 1'b0);
        @(negedge clk);
        check("R11 idle hold", 64'h44332211, 1'b0, 1'b0);
        @(negedge clk);
        check("R11 idle hold 2", 64'h44332211, 1'b0, 1'b0);

        // R3: literal flag low, literal garbage ignored, B low byte used
        valid_i = 1'b1; func_i = 7'h0B; opa_i = A; opb_i = 64'hFF00; lit_i = 8'h07;
        use_lit_i = 1'b0; src_a_idx_i = 5'd1;
        @(negedge clk);
        valid_i = 1'b0;
        check("R3 literal ignored", 64'h11, 1'b1, 1'b0);

        // R12: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R12 reset again", 64'h0, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule